// File: doc/BRIEF.md
# Multi-cycle instruction sequencer

This block paces a 16-bit word-addressed processor. It owns the program counter. It reads the instruction stream through a single read port and splits each first word into an opcode and two 6-bit operand selectors. It pulls in any extra operand words the selectors call for, and holds each instruction for a fixed number of cycles that depends on its opcode and operands. The operand unit, the ALU and the stack logic sit outside. The sequencer hands them the operand selectors, a write strobe for each extra word, a one-cycle ALU start pulse and a one-cycle call pulse. It takes back a comparison result, a call target and an optional PC write.

The memory port has no wait states: read data belongs to the address driven in the same cycle. Every instruction-stream read uses the word at `pc` and then advances `pc` by one. All work for an instruction happens in its last cycle. The ALU pulse, the call pulse and the extra-word strobe for a word read in that cycle all see the same data, so the outside units resolve operand values combinationally.

A failed comparison costs one more cycle. In that cycle the first word of the following instruction is read and its length decoded from it, and `pc` jumps over the whole instruction without disturbing anything else. `inst_start` and `inst_done` frame every instruction, so cycle costs can be measured at the ports.

Top module: `instr_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `pc` is 0x0000, `inst_start` is high, a read of address 0 is requested and `inst_done` is low unless that instruction costs 1 cycle.
- R2: Each instruction-stream read drives `mem_addr` with the current `pc`, and `pc` is one higher in the next cycle unless a load or a skip applies.
- R3: For a nonzero opcode in bits [3:0], bits [9:4] go out on `opnd_a_code` and bits [15:10] on `opnd_b_code`. An extra word for operand a is read before one for operand b, and `opnd_word_sel` is 0 for a and 1 for b. For opcode 0, bits [9:4] are an extended opcode and bits [15:10] go out on `opnd_a_code`.
- R4: Base costs by opcode: 1 for 0x1, 0x9, 0xa and 0xb; 2 for 0x2, 0x3, 0x4, 0x7 and 0x8; 3 for 0x5 and 0x6; 2 for the tests 0xc to 0xf.
- R5: Each operand selector in 0x10 to 0x17, 0x1e or 0x1f adds one word to the instruction and one cycle to its cost. The word is presented on `opnd_word` with `opnd_word_we` high. No other selector reads a word.
- R6: For opcodes 0xc to 0xf, `alu_cond` is sampled in the `alu_go` cycle. When it is low, one more cycle reads the next instruction's first word and adds that instruction's length (1 + its extra words; 1 for a reserved extended opcode) to `pc`. That cycle has no `alu_go`, `opnd_word_we` or `call_go`.
- R7: Extended opcode 0x01 is a call costing 2 cycles plus its operand's extra word. In its last cycle `call_go` is high with `call_ret` equal to the address after the call's final word, and `pc` takes `opnd_a_val` on the next cycle.
- R8: Extended opcodes 0x00 and 0x02 to 0x3f take 1 cycle and advance `pc` by 1. They read no operand word and raise neither `alu_go` nor `call_go`.
- R9: `pc_load` with `pc_wdata` replaces `pc` only in an `alu_go` cycle, where it wins over the increment. In every other cycle it has no effect.
- R10: `inst_start` is high in the first cycle of each instruction and `inst_done` in its last. The cycles from one to the other inclusive equal the instruction's cost, and the cycle after `inst_done` starts the next instruction.
- R11: In the `alu_go` cycle, `alu_op` equals bits [3:0] of the instruction's first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd | output | 1 | Instruction-stream read this cycle |
| mem_addr | output | AW | Read address (current PC) |
| mem_rdata | input | 16 | Word at `mem_addr`, same cycle |
| opnd_a_code | output | 6 | Operand a selector (sole operand for extended opcodes) |
| opnd_b_code | output | 6 | Operand b selector |
| opnd_word_we | output | 1 | Extra operand word present on `opnd_word` |
| opnd_word_sel | output | 1 | Extra word belongs to a (0) or b (1) |
| opnd_word | output | 16 | Extra operand word |
| opnd_a_val | input | AW | Resolved operand value used as call target |
| alu_go | output | 1 | Execute pulse to the ALU |
| alu_op | output | 4 | Opcode for the ALU |
| alu_cond | input | 1 | Comparison result, high when the test holds |
| pc_load | input | 1 | Write-back targets the PC |
| pc_wdata | input | AW | Value written to the PC |
| call_go | output | 1 | Call pulse to the stack logic |
| call_ret | output | AW | Return address to push |
| pc | output | AW | Program counter |
| inst_start | output | 1 | First cycle of an instruction |
| inst_done | output | 1 | Last cycle of an instruction |

## Verification
The bench builds the block with its default 16-bit address width and backs it with a 256-word memory that uses the low address bits. Every opcode cost class, each operand length (zero, one and two extra words), calls with short and long targets, and skips over one-, two- and three-word instructions fit within that window. The outside units are modelled as static inputs: a fixed comparison result, a fixed call target and a PC write that stays asserted. This shows both that the write is taken in an ALU cycle and that it is ignored in all other cycles.

// File: rtl/instr_seq_pkg.sv
`timescale 1ns/1ps
package instr_seq_pkg;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned OPC_W  = 4;
  localparam int unsigned SEL_W  = 6;
  localparam int unsigned COST_W = 3;
  localparam int unsigned LEN_W  = 2;

  typedef struct packed {
    logic [OPC_W-1:0]  op;
    logic [SEL_W-1:0]  a_code;
    logic [SEL_W-1:0]  b_code;
    logic              is_call;
    logic              is_nop;
    logic              is_cond;
    logic              wa;
    logic              wb;
    logic [LEN_W-1:0]  len;
    logic [COST_W-1:0] cost;
  } dec_t;

  // selector codes that pull one more word from the stream
  function automatic logic sel_reads_word(input logic [SEL_W-1:0] c);
    return (c[5:3] == 3'b010) || (c == 6'h1e) || (c == 6'h1f);
  endfunction

  // fixed part of the cost of a two-operand opcode
  function automatic logic [COST_W-1:0] op_base_cost(input logic [OPC_W-1:0] op);
    logic [COST_W-1:0] c;
    case (op)
      4'h1, 4'h9, 4'ha, 4'hb: c = 3'd1;
      4'h5, 4'h6:             c = 3'd3;
      default:                c = 3'd2;
    endcase
    return c;
  endfunction

  function automatic dec_t split_word(input logic [WORD_W-1:0] w);
    dec_t d;
    d.op = w[3:0];
    if (w[3:0] == 4'h0) begin
      d.a_code  = w[15:10];
      d.b_code  = '0;
      d.is_call = (w[9:4] == 6'h01);
      d.is_nop  = (w[9:4] != 6'h01);
      d.is_cond = 1'b0;
      d.wa      = d.is_call && sel_reads_word(w[15:10]);
      d.wb      = 1'b0;
      d.cost    = d.is_call ? (3'd2 + {2'b00, d.wa}) : 3'd1;
    end else begin
      d.a_code  = w[9:4];
      d.b_code  = w[15:10];
      d.is_call = 1'b0;
      d.is_nop  = 1'b0;
      d.is_cond = (w[3:2] == 2'b11);
      d.wa      = sel_reads_word(w[9:4]);
      d.wb      = sel_reads_word(w[15:10]);
      d.cost    = op_base_cost(w[3:0]) + {2'b00, d.wa} + {2'b00, d.wb};
    end
    d.len = 2'd1 + {1'b0, d.wa} + {1'b0, d.wb};
    return d;
  endfunction

endpackage

// File: rtl/instr_decode.sv
`timescale 1ns/1ps
module instr_decode
  import instr_seq_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output dec_t              dec
);
  always_comb dec = split_word(word);
endmodule

// File: rtl/seq_pc.sv
`timescale 1ns/1ps
module seq_pc #(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          skip_en,
  input  logic [LW-1:0] skip_len,
  output logic [AW-1:0] pc
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] pc_q;
  logic          step_evt;
  logic          hop_evt;

  assign step_evt = inc && !load && !skip_en;
  assign hop_evt  = skip_en && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc_q <= '0;
    else if (load)     pc_q <= load_val;
    else if (skip_en)  pc_q <= pc_q + {{(AW-LW){1'b0}}, skip_len};
    else if (inc)      pc_q <= pc_q + ONE;
  end

  assign pc = pc_q;

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> pc == $past(pc) + ONE);

  // R6
  skip_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hop_evt |=> pc == $past(pc) + {{(AW-LW){1'b0}}, $past(skip_len)});

endmodule

// File: rtl/instr_seq.sv
`timescale 1ns/1ps
module instr_seq
  import instr_seq_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [SEL_W-1:0]  opnd_a_code,
  output logic [SEL_W-1:0]  opnd_b_code,
  output logic              opnd_word_we,
  output logic              opnd_word_sel,
  output logic [WORD_W-1:0] opnd_word,
  input  logic [AW-1:0]     opnd_a_val,
  output logic              alu_go,
  output logic [OPC_W-1:0]  alu_op,
  input  logic              alu_cond,
  input  logic              pc_load,
  input  logic [AW-1:0]     pc_wdata,
  output logic              call_go,
  output logic [AW-1:0]     call_ret,
  output logic [AW-1:0]     pc,
  output logic              inst_start,
  output logic              inst_done
);

  typedef enum logic [1:0] {S_FETCH, S_RUN, S_SKIP} st_t;

  st_t               st;
  dec_t              dec_w;
  logic [OPC_W-1:0]  ir_op;
  logic [SEL_W-1:0]  ir_a, ir_b;
  logic              ir_call, ir_nop, ir_cond;
  logic [COST_W-1:0] remain;
  logic              pend_a, pend_b;

  // named internal events
  logic              in_fetch, in_run, in_skip;
  logic              fetch_last, run_last, last_cyc;
  logic              word_cyc, test_fail, pc_ld;
  logic [AW-1:0]     pc_ld_val;
  logic [OPC_W-1:0]  cur_op;
  logic              cur_call, cur_nop, cur_cond;
  logic [COST_W-1:0] cyc_cnt;

  instr_decode u_dec (
    .word (mem_rdata),
    .dec  (dec_w)
  );

  assign in_fetch = (st == S_FETCH);
  assign in_run   = (st == S_RUN);
  assign in_skip  = (st == S_SKIP);

  // the first word is decoded live in the fetch cycle, latched after it
  assign cur_op   = in_fetch ? dec_w.op      : ir_op;
  assign cur_call = in_fetch ? dec_w.is_call : ir_call;
  assign cur_nop  = in_fetch ? dec_w.is_nop  : ir_nop;
  assign cur_cond = in_fetch ? dec_w.is_cond : ir_cond;

  assign fetch_last = in_fetch && (dec_w.cost == 3'd1);
  assign run_last   = in_run && (remain == 3'd1);
  assign last_cyc   = fetch_last || run_last;
  assign word_cyc   = in_run && (pend_a || pend_b);

  assign mem_rd   = in_fetch || word_cyc || in_skip;
  assign mem_addr = pc;

  assign opnd_a_code   = in_fetch ? dec_w.a_code : ir_a;
  assign opnd_b_code   = in_fetch ? dec_w.b_code : ir_b;
  assign opnd_word_we  = word_cyc;
  assign opnd_word_sel = !pend_a;
  assign opnd_word     = mem_rdata;

  assign alu_go    = last_cyc && !cur_call && !cur_nop;
  assign alu_op    = cur_op;
  assign test_fail = alu_go && cur_cond && !alu_cond;

  assign call_go   = last_cyc && cur_call;
  assign call_ret  = pc + {{(AW-1){1'b0}}, word_cyc};

  assign inst_start = in_fetch;
  assign inst_done  = (last_cyc && !test_fail) || in_skip;

  assign pc_ld     = call_go || (alu_go && pc_load);
  assign pc_ld_val = call_go ? opnd_a_val : pc_wdata;

  seq_pc #(.AW(AW), .LW(LEN_W)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (mem_rd && !in_skip),
    .load     (pc_ld),
    .load_val (pc_ld_val),
    .skip_en  (in_skip),
    .skip_len (dec_w.len),
    .pc       (pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_FETCH;
      ir_op   <= '0;
      ir_a    <= '0;
      ir_b    <= '0;
      ir_call <= 1'b0;
      ir_nop  <= 1'b0;
      ir_cond <= 1'b0;
      remain  <= '0;
      pend_a  <= 1'b0;
      pend_b  <= 1'b0;
    end else begin
      case (st)
        S_FETCH: begin
          ir_op   <= dec_w.op;
          ir_a    <= dec_w.a_code;
          ir_b    <= dec_w.b_code;
          ir_call <= dec_w.is_call;
          ir_nop  <= dec_w.is_nop;
          ir_cond <= dec_w.is_cond;
          if (!fetch_last) begin
            remain <= dec_w.cost - 3'd1;
            pend_a <= dec_w.wa;
            pend_b <= dec_w.wb;
            st     <= S_RUN;
          end
        end
        S_RUN: begin
          remain <= remain - 3'd1;
          if (pend_a)      pend_a <= 1'b0;
          else if (pend_b) pend_b <= 1'b0;
          if (run_last) st <= test_fail ? S_SKIP : S_FETCH;
        end
        default: st <= S_FETCH;
      endcase
    end
  end

  // cycles spent in the current instruction, for the cost bound
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cyc_cnt <= '0;
    else if (inst_done) cyc_cnt <= '0;
    else                cyc_cnt <= cyc_cnt + 3'd1;
  end

  // R10
  next_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inst_done |=> inst_start);

  // R4
  cost_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inst_done |-> cyc_cnt <= 3'd4);

  // R6
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_fail |=> mem_rd && inst_done && !alu_go && !opnd_word_we && !call_go);

  // R7
  call_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_go |=> pc == $past(opnd_a_val));

  // R9
  pcload_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load && in_run && !word_cyc && !alu_go && !call_go |=> pc == $past(pc));

  // R8
  reserved_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fetch && cur_nop |-> inst_done && !alu_go && !call_go && !opnd_word_we);

endmodule

// File: tb/sim_instr_seq.sv
`timescale 1ns/1ps
module sim_instr_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_rd;
  logic [15:0] mem_addr, mem_rdata;
  logic [5:0]  opnd_a_code, opnd_b_code;
  logic        opnd_word_we, opnd_word_sel;
  logic [15:0] opnd_word;
  logic [15:0] opnd_a_val = '0;
  logic        alu_go;
  logic [3:0]  alu_op;
  logic        alu_cond = 1'b0;
  logic        pc_load = 1'b0;
  logic [15:0] pc_wdata = '0;
  logic        call_go;
  logic [15:0] call_ret, pc;
  logic        inst_start, inst_done;

  logic [15:0] mem [0:255];
  assign mem_rdata = mem[mem_addr[7:0]];

  int n_chk = 0;
  int n_fail = 0;
  int first_sel;
  int cap_op;
  int cap_ret;

  always #2.5 clk = ~clk;

  instr_seq u0 (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .opnd_a_code(opnd_a_code), .opnd_b_code(opnd_b_code),
    .opnd_word_we(opnd_word_we), .opnd_word_sel(opnd_word_sel),
    .opnd_word(opnd_word), .opnd_a_val(opnd_a_val), .alu_go(alu_go),
    .alu_op(alu_op), .alu_cond(alu_cond), .pc_load(pc_load),
    .pc_wdata(pc_wdata), .call_go(call_go), .call_ret(call_ret), .pc(pc),
    .inst_start(inst_start), .inst_done(inst_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // runs one instruction from its start cycle; ends at the next start cycle
  task automatic run_instr(input string req, input int exp_cyc, input int exp_pc,
                           input int exp_words, input int exp_alu, input int exp_call);
    int cyc = 0;
    int words = 0;
    int alus = 0;
    int calls = 0;
    bit fin = 1'b0;
    first_sel = -1;
    chk(inst_start === 1'b1, "R10", "start flag", inst_start, 1);
    while (!fin && cyc < 20) begin
      cyc++;
      if (opnd_word_we) begin
        if (words == 0) first_sel = opnd_word_sel;
        words++;
      end
      if (alu_go) begin alus++; cap_op = alu_op; end
      if (call_go) begin calls++; cap_ret = call_ret; end
      if (inst_done) fin = 1'b1;
      @(negedge clk);
    end
    chk(cyc == exp_cyc, req, "cycles", cyc, exp_cyc);
    chk(pc == exp_pc[15:0], req, "pc", pc, exp_pc);
    chk(words == exp_words, req, "operand words", words, exp_words);
    chk(alus == exp_alu, req, "alu pulses", alus, exp_alu);
    chk(calls == exp_call, req, "call pulses", calls, exp_call);
  endtask

  task automatic t_reset();
    clear_mem();
    mem[0] = 16'h7DE5;
    do_reset();
    chk(pc == 16'h0000, "R1", "pc after reset", pc, 0);
    chk(inst_start === 1'b1, "R1", "start after reset", inst_start, 1);
    chk(mem_rd === 1'b1 && mem_addr == 16'h0000, "R1", "first read", mem_addr, 0);
    chk(inst_done === 1'b0, "R1", "done after reset", inst_done, 0);
    chk(opnd_a_code == 6'h1e, "R3", "a selector", opnd_a_code, 'h1e);
    chk(opnd_b_code == 6'h1f, "R3", "b selector", opnd_b_code, 'h1f);
  endtask

  task automatic t_costs();
    clear_mem();
    mem[0] = 16'h0401; mem[1] = 16'h0402; mem[2] = 16'h0406;
    mem[3] = 16'h0405; mem[4] = 16'h0407; mem[5] = 16'h0409;
    do_reset();
    run_instr("R4", 1, 1, 0, 1, 0); chk(cap_op == 1, "R11", "alu_op", cap_op, 1);
    run_instr("R4", 2, 2, 0, 1, 0); chk(cap_op == 2, "R11", "alu_op", cap_op, 2);
    run_instr("R4", 3, 3, 0, 1, 0); chk(cap_op == 6, "R11", "alu_op", cap_op, 6);
    run_instr("R4", 3, 4, 0, 1, 0); chk(cap_op == 5, "R11", "alu_op", cap_op, 5);
    run_instr("R4", 2, 5, 0, 1, 0);
    run_instr("R4", 1, 6, 0, 1, 0); chk(cap_op == 9, "R11", "alu_op", cap_op, 9);
  endtask

  task automatic t_words();
    clear_mem();
    mem[0] = 16'h7C01; mem[1] = 16'h0030;
    mem[2] = 16'h7DE5; mem[3] = 16'h1000; mem[4] = 16'h0020;
    mem[5] = 16'h01E3; mem[6] = 16'h2000;
    mem[7] = 16'h0101; mem[8] = 16'h0004;
    do_reset();
    run_instr("R5", 2, 2, 1, 1, 0);
    chk(first_sel == 1, "R3", "word owner b", first_sel, 1);
    run_instr("R5", 5, 5, 2, 1, 0);
    chk(first_sel == 0, "R3", "a word first", first_sel, 0);
    run_instr("R5", 3, 7, 1, 1, 0);
    chk(first_sel == 0, "R3", "word owner a", first_sel, 0);
    run_instr("R5", 2, 9, 1, 1, 0);
  endtask

  task automatic t_test_pass();
    clear_mem();
    mem[0] = 16'h040C; mem[1] = 16'h0401;
    alu_cond = 1'b1;
    do_reset();
    run_instr("R6", 2, 1, 0, 1, 0);
    run_instr("R6", 1, 2, 0, 1, 0);
    alu_cond = 1'b0;
  endtask

  task automatic t_test_fail();
    alu_cond = 1'b0;
    clear_mem();
    mem[0] = 16'h040C; mem[1] = 16'h7DE5; mem[2] = 16'h1111; mem[3] = 16'h2222;
    mem[4] = 16'h0401;
    do_reset();
    run_instr("R6", 3, 4, 0, 1, 0);
    run_instr("R6", 1, 5, 0, 1, 0);
    clear_mem();
    mem[0] = 16'h81FD; mem[1] = 16'h1234; mem[2] = 16'h7C10; mem[3] = 16'h0050;
    mem[4] = 16'h0401;
    do_reset();
    run_instr("R6", 4, 4, 1, 1, 0);
    run_instr("R6", 1, 5, 0, 1, 0);
    clear_mem();
    mem[0] = 16'h040C; mem[1] = 16'h7C20; mem[2] = 16'h0401;
    do_reset();
    run_instr("R6", 3, 2, 0, 1, 0);
  endtask

  task automatic t_call();
    clear_mem();
    mem[0] = 16'h7C10; mem[1] = 16'h0040;
    mem[16'h40] = 16'h8410;
    pc_load = 1'b1; pc_wdata = 16'h00AA;
    opnd_a_val = 16'h0040;
    do_reset();
    chk(opnd_a_code == 6'h1f, "R3", "call operand selector", opnd_a_code, 'h1f);
    run_instr("R7", 3, 'h40, 1, 0, 1);
    chk(cap_ret == 2, "R7", "return address", cap_ret, 2);
    opnd_a_val = 16'h0080;
    run_instr("R9", 2, 'h80, 0, 0, 1);
    chk(cap_ret == 'h41, "R7", "return address short", cap_ret, 'h41);
    pc_load = 1'b0;
  endtask

  task automatic t_reserved();
    clear_mem();
    mem[0] = 16'h0000; mem[1] = 16'h7C20; mem[2] = 16'hFFE0;
    pc_load = 1'b1; pc_wdata = 16'h00CC;
    do_reset();
    run_instr("R8", 1, 1, 0, 0, 0);
    run_instr("R8", 1, 2, 0, 0, 0);
    run_instr("R9", 1, 3, 0, 0, 0);
    pc_load = 1'b0;
  endtask

  task automatic t_pc_load();
    clear_mem();
    mem[0] = 16'h95C1;
    mem[16'h30] = 16'h7DC1; mem[16'h31] = 16'h7777;
    mem[16'h60] = 16'h0401;
    pc_load = 1'b1; pc_wdata = 16'h0030;
    do_reset();
    run_instr("R9", 1, 'h30, 0, 1, 0);
    pc_wdata = 16'h0060;
    run_instr("R9", 2, 'h60, 1, 1, 0);
    pc_load = 1'b0;
    run_instr("R2", 1, 'h61, 0, 1, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_costs();
    t_words();
    t_test_pass();
    t_test_fail();
    t_call();
    t_reserved();
    t_pc_load();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule